// File: doc/BRIEF.md
# Blocking Fetch-Execute Memory Sequencer

This block is the control sequencer of a non-pipelined, single-thread processor that keeps at most one memory access in flight. It fetches an instruction over an instruction request port. For a memory instruction it then issues one data request over a data request port. After that it starts the next fetch. Address translation, cache contents, decoding and the datapath sit outside the block. They appear here only as plain inputs: a fetch-fault flag, a memory-reference flag and a failed-locked-store flag that arrive with the instruction response.

Each port has a request valid that the target accepts in the same cycle. A rejected request is held, and it is reissued only in a cycle where the matching retry pulse is present. A response is a one-cycle valid that is sampled on the rising clock edge.

Around this sequencing sit the thread commands:
- activate, with a start delay in cycles;
- suspend;
- switch-out;
- a drain request, which is held as a level and is acknowledged only once no access is outstanding.

Top module: `fetch_seq`

## Requirements
- R1: After reset the state output is idle (code 0), no request is driven, and busy, error and drain acknowledge are all low.
- R2: Activate sampled in the idle state moves the state to running (code 1). If D is the value on the delay input, the first fetch request is presented D+1 cycles after the cycle in which activate was sampled.
- R3: When a fetch request is accepted, the state becomes instruction-wait (code 3). When it is rejected, the state becomes instruction-retry (code 2).
- R4: In instruction-retry (code 2) or data-retry (code 4), a request is driven only in a cycle that carries the matching retry pulse. If that request is accepted the state moves to the wait state (code 3 or 5); otherwise it stays where it is.
- R5: An instruction response in instruction-wait pulses the instruction-valid output and returns the state to running. For a non-memory instruction, the next fetch request is presented in the following cycle.
- R6: For a memory instruction, the data request is driven in the same cycle as the instruction response. If it is accepted the state becomes data-wait (code 5); otherwise it becomes data-retry (code 4). A data response pulses data-done and returns the state to running, and the next fetch follows.
- R7: A memory instruction flagged as a failed locked store drives no data request. It completes in the same cycle and returns the state to running.
- R8: A fetch that would fault drives no fetch request. It pulses the fault-redirect output, the state stays running, and fetch is tried again in the next cycle.
- R9: A drain request raised in idle, running or switched-out is acknowledged in the next cycle. Raised in any other state, it is acknowledged in the cycle after the pending instruction or data response. An instruction response received while draining gives no instruction-valid. No fetch is issued while drain is requested. The acknowledge drops in the cycle after the drain request drops.
- R10: Suspend in running moves the state to idle, and no further fetch starts.
- R11: Switch-out in running or idle moves the state to switched-out (code 6). This cancels a delayed fetch start that is still pending, and no request is driven afterwards.
- R12: An illegal event raises a sticky error flag and changes nothing else. The illegal events are: suspend outside running; activate outside idle; switch-out outside running/idle; a retry pulse outside the matching retry state; a response outside the matching wait state.
- R13: At most one of the two request outputs is high in any cycle. Busy is high exactly in states 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate_i | input | 1 | Start the thread (legal in idle) |
| act_delay_i | input | DLY_W | Start delay in cycles |
| suspend_i | input | 1 | Stop the thread (legal in running) |
| switch_out_i | input | 1 | Hand the thread off (legal in running/idle) |
| drain_req_i | input | 1 | Drain request, held as a level |
| drain_ack_o | output | 1 | Drain acknowledged |
| if_req_o | output | 1 | Instruction fetch request valid |
| if_accept_i | input | 1 | Fetch request accepted this cycle |
| if_retry_i | input | 1 | Instruction port retry pulse |
| if_fault_i | input | 1 | Current fetch would fault |
| if_rsp_i | input | 1 | Instruction response valid |
| if_is_mem_i | input | 1 | Responding instruction is a memory reference |
| if_lock_fail_i | input | 1 | Responding instruction is a failed locked store |
| d_req_o | output | 1 | Data request valid |
| d_accept_i | input | 1 | Data request accepted this cycle |
| d_retry_i | input | 1 | Data port retry pulse |
| d_rsp_i | input | 1 | Data response valid |
| inst_valid_o | output | 1 | Instruction delivered to the execute unit |
| fault_redirect_o | output | 1 | Fetch fault, PC redirected to the handler |
| data_done_o | output | 1 | Data access completed |
| busy_o | output | 1 | A request is held or outstanding |
| err_o | output | 1 | Sticky illegal-event flag |
| state_o | output | 3 | Current state code |

## Verification
The in-module properties watch these rules on every cycle:
- only one request is live at a time;
- an accepted fetch lands in instruction-wait;
- a retry state is left only through a retry pulse;
- suspend reaches idle;
- a failed locked store never reaches the data port;
- no fetch starts while drain is acknowledged;
- the error flag stays set.

Some behaviour can be seen only through the bench's scenarios, which compare every cycle against an independent model:
- the exact start delay after activate;
- a pending delayed start cancelled by switch-out;
- the drain acknowledge waiting for an outstanding response;
- discarded instructions under drain;
- the next fetch following completion by one cycle.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             switch_out_i,
  input  logic             drain_req_i,
  output logic             drain_ack_o,
  output logic             if_req_o,
  input  logic             if_accept_i,
  input  logic             if_retry_i,
  input  logic             if_fault_i,
  input  logic             if_rsp_i,
  input  logic             if_is_mem_i,
  input  logic             if_lock_fail_i,
  output logic             d_req_o,
  input  logic             d_accept_i,
  input  logic             d_retry_i,
  input  logic             d_rsp_i,
  output logic             inst_valid_o,
  output logic             fault_redirect_o,
  output logic             data_done_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [2:0]       state_o
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RUN = 3'd1, S_IRETRY = 3'd2, S_IWAIT = 3'd3,
    S_DRETRY = 3'd4, S_DWAIT = 3'd5, S_SWOUT = 3'd6
  } st_t;

  st_t st, st_n;
  logic [DLY_W-1:0] cnt, cnt_n;
  logic drained, err;
  logic fetch_go, quiet, illegal, drain_done;

  assign fetch_go = (st == S_RUN) && (cnt == '0) && !drain_req_i && !suspend_i && !switch_out_i;
  assign fault_redirect_o = fetch_go && if_fault_i;
  assign if_req_o = (fetch_go && !if_fault_i) || (st == S_IRETRY && if_retry_i);
  assign inst_valid_o = (st == S_IWAIT) && if_rsp_i && !drain_req_i;
  assign d_req_o = (inst_valid_o && if_is_mem_i && !if_lock_fail_i) || (st == S_DRETRY && d_retry_i);
  assign data_done_o = (st == S_DWAIT) && d_rsp_i;
  assign busy_o = (st == S_IRETRY) || (st == S_IWAIT) || (st == S_DRETRY) || (st == S_DWAIT);
  assign quiet = (st == S_IDLE) || (st == S_RUN) || (st == S_SWOUT);
  assign drain_done = quiet || (st == S_IWAIT && if_rsp_i) || data_done_o;
  assign drain_ack_o = drained;
  assign err_o = err;
  assign state_o = st;

  assign illegal = (suspend_i && st != S_RUN) || (activate_i && st != S_IDLE) ||
                   (switch_out_i && !(st == S_RUN || st == S_IDLE)) ||
                   (if_retry_i && st != S_IRETRY) || (d_retry_i && st != S_DRETRY) ||
                   (if_rsp_i && st != S_IWAIT) || (d_rsp_i && st != S_DWAIT);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_IDLE:
        if (switch_out_i) st_n = S_SWOUT;
        else if (activate_i) begin
          st_n  = S_RUN;
          cnt_n = act_delay_i;
        end
      S_RUN:
        if (switch_out_i) begin
          st_n  = S_SWOUT;
          cnt_n = '0;
        end else if (suspend_i) begin
          st_n  = S_IDLE;
          cnt_n = '0;
        end else if (cnt != '0) cnt_n = cnt - 1'b1;
        else if (if_req_o) st_n = if_accept_i ? S_IWAIT : S_IRETRY;
      S_IRETRY:
        if (if_retry_i && if_accept_i) st_n = S_IWAIT;
      S_IWAIT:
        if (if_rsp_i) begin
          if (d_req_o) st_n = d_accept_i ? S_DWAIT : S_DRETRY;
          else st_n = S_RUN;
        end
      S_DRETRY:
        if (d_retry_i && d_accept_i) st_n = S_DWAIT;
      S_DWAIT:
        if (d_rsp_i) st_n = S_RUN;
      default: st_n = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      drained <= 1'b0;
      err     <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      drained <= drain_req_i && (drained || drain_done);
      err     <= err || illegal;
    end
  end

  p_one_req_r13: assert property (@(posedge clk) disable iff (!rst_n) !(if_req_o && d_req_o));
  p_accept_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && if_req_o && if_accept_i) |=> (st == S_IWAIT));
  p_retry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IRETRY && !if_retry_i) |=> (st == S_IRETRY));
  p_suspend_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && suspend_i && !switch_out_i) |=> (st == S_IDLE));
  p_lock_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IWAIT && if_rsp_i && if_lock_fail_i) |-> !d_req_o);
  p_drain_nofetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_ack_o && drain_req_i) |-> !if_req_o);
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o);

endmodule

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;
  localparam int DLY_W = 8;
  logic clk = 0, rst_n = 0;
  logic act = 0, susp = 0, swo = 0, drain = 0;
  logic [DLY_W-1:0] dly = '0;
  logic iacc = 0, iret = 0, ifault = 0, irsp = 0, imem = 0, ilock = 0;
  logic dacc = 0, dret = 0, drsp = 0;
  logic ack, ifv, dv, ival, fred, ddone, busy, err;
  logic [2:0] st;

  always #2.5 clk = ~clk;

  fetch_seq #(.DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .act_delay_i(dly), .suspend_i(susp),
    .switch_out_i(swo), .drain_req_i(drain), .drain_ack_o(ack), .if_req_o(ifv),
    .if_accept_i(iacc), .if_retry_i(iret), .if_fault_i(ifault), .if_rsp_i(irsp),
    .if_is_mem_i(imem), .if_lock_fail_i(ilock), .d_req_o(dv), .d_accept_i(dacc),
    .d_retry_i(dret), .d_rsp_i(drsp), .inst_valid_o(ival), .fault_redirect_o(fred),
    .data_done_o(ddone), .busy_o(busy), .err_o(err), .state_o(st));

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_st = 0;
  logic [DLY_W-1:0] m_cnt = '0;
  logic m_drn = 0, m_err = 0;
  logic o_ifv, o_dv, o_ival, o_fred, o_ddone;

  task automatic chk(input logic [31:0] a, input logic [31:0] e, input string tag);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, a, e, $time);
    end
  endtask

  function automatic logic is_busy(input logic [2:0] s);
    return s >= 3'd2 && s <= 3'd5;
  endfunction

  task automatic cycle();
    logic go, e_ifv, e_dv, e_ival, e_fred, e_dd, quiet;
    logic [2:0] n_st;
    logic [DLY_W-1:0] n_cnt;
    @(negedge clk);
    go     = m_st == 1 && m_cnt == 0 && !drain && !susp && !swo;
    e_fred = go && ifault;
    e_ifv  = (go && !ifault) || (m_st == 2 && iret);
    e_ival = m_st == 3 && irsp && !drain;
    e_dv   = (e_ival && imem && !ilock) || (m_st == 4 && dret);
    e_dd   = m_st == 5 && drsp;
    o_ifv = ifv; o_dv = dv; o_ival = ival; o_fred = fred; o_ddone = ddone;
    chk(st, m_st, "R13 state");
    chk(busy, is_busy(m_st), "R13 busy");
    chk(ifv, e_ifv, "R3 fetch request");
    chk(dv, e_dv, "R6 data request");
    chk(ival, e_ival, "R5 inst valid");
    chk(fred, e_fred, "R8 fault redirect");
    chk(ddone, e_dd, "R6 data done");
    chk(ack, m_drn, "R9 drain ack");
    chk(err, m_err, "R12 error");
    n_st = m_st; n_cnt = m_cnt;
    case (m_st)
      0: if (swo) n_st = 6; else if (act) begin n_st = 1; n_cnt = dly; end
      1: if (swo) begin n_st = 6; n_cnt = 0; end
         else if (susp) begin n_st = 0; n_cnt = 0; end
         else if (m_cnt != 0) n_cnt = m_cnt - 1;
         else if (e_ifv) n_st = iacc ? 3'd3 : 3'd2;
      2: if (iret && iacc) n_st = 3;
      3: if (irsp) n_st = e_dv ? (dacc ? 3'd5 : 3'd4) : 3'd1;
      4: if (dret && dacc) n_st = 5;
      5: if (drsp) n_st = 1;
      default: ;
    endcase
    quiet = m_st == 0 || m_st == 1 || m_st == 6;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_drn = 0; m_err = 0;
    end else begin
      m_drn = drain && (m_drn || quiet || (m_st == 3 && irsp) || e_dd);
      m_err = m_err || (susp && m_st != 1) || (act && m_st != 0) ||
              (swo && !(m_st == 1 || m_st == 0)) || (iret && m_st != 2) ||
              (dret && m_st != 4) || (irsp && m_st != 3) || (drsp && m_st != 5);
      m_st = n_st; m_cnt = n_cnt;
    end
    act = 0; susp = 0; swo = 0; iacc = 0; iret = 0; ifault = 0;
    irsp = 0; imem = 0; ilock = 0; dacc = 0; dret = 0; drsp = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; drain = 0;
    cycle(); cycle();
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk(st, 0, "R1 reset state"); chk(ifv | dv, 0, "R1 no request");
    chk(busy | err | ack, 0, "R1 flags low");
    @(posedge clk); #1;

    act = 1; dly = 2; cycle();
    chk(st, 1, "R2 running");
    cycle(); chk(o_ifv, 0, "R2 delay cycle 1");
    cycle(); chk(o_ifv, 0, "R2 delay cycle 2");
    iacc = 0; cycle(); chk(o_ifv, 1, "R2 first fetch at D+1");
    chk(st, 2, "R3 reject to retry");
    cycle(); chk(o_ifv, 0, "R4 no resend without retry"); chk(st, 2, "R4 hold");
    iret = 1; cycle(); chk(o_ifv, 1, "R4 resend on retry"); chk(st, 2, "R4 rejected resend");
    iret = 1; iacc = 1; cycle(); chk(st, 3, "R4 retry accepted");
    irsp = 1; cycle(); chk(o_ival, 1, "R5 inst valid"); chk(st, 1, "R5 back to running");
    iacc = 1; cycle(); chk(o_ifv, 1, "R5 next fetch"); chk(st, 3, "R3 accept to wait");
    irsp = 1; imem = 1; ilock = 1; cycle();
    chk(o_dv, 0, "R7 no data request"); chk(o_ival, 1, "R7 completes"); chk(st, 1, "R7 running");
    iacc = 1; cycle();
    irsp = 1; imem = 1; dacc = 0; cycle(); chk(o_dv, 1, "R6 data request"); chk(st, 4, "R6 data retry");
    dret = 1; dacc = 1; cycle(); chk(st, 5, "R4 data retry accepted");
    drain = 1; cycle(); chk(ack, 0, "R9 pending drain not acked");
    drsp = 1; cycle(); chk(o_ddone, 1, "R6 data done"); chk(st, 1, "R6 running");
    cycle(); chk(o_ifv, 0, "R9 no fetch while draining"); chk(ack, 1, "R9 acked after response");
    drain = 0; ifault = 1; cycle(); chk(o_fred, 1, "R8 fault redirect"); chk(o_ifv, 0, "R8 no fetch");
    chk(st, 1, "R8 still running"); chk(ack, 0, "R9 ack drops");
    susp = 1; cycle(); chk(st, 0, "R10 suspended");
    for (int i = 0; i < 3; i++) begin cycle(); chk(o_ifv, 0, "R10 no fetch after suspend"); end
    susp = 1; cycle(); chk(err, 1, "R12 illegal suspend"); chk(st, 0, "R12 state unchanged");
    act = 1; dly = 5; cycle(); swo = 1; cycle(); chk(st, 6, "R11 switched out");
    for (int i = 0; i < 8; i++) begin cycle(); chk(o_ifv, 0, "R11 delayed fetch cancelled"); end
    drain = 1; cycle(); cycle(); chk(ack, 1, "R9 drain in switched-out");

    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 4) drain = ~drain;
      iacc = $urandom_range(99) < 60;
      dacc = $urandom_range(99) < 60;
      case (m_st)
        0: begin act = $urandom_range(99) < 30; dly = $urandom_range(3); swo = $urandom_range(99) < 2; end
        1: begin susp = $urandom_range(99) < 4; swo = $urandom_range(99) < 1; ifault = $urandom_range(99) < 10; end
        2: iret = $urandom_range(99) < 40;
        3: begin irsp = $urandom_range(99) < 40; imem = $urandom_range(99) < 50; ilock = $urandom_range(99) < 20; end
        4: dret = $urandom_range(99) < 40;
        5: drsp = $urandom_range(99) < 40;
        default: ;
      endcase
      if ($urandom_range(999) < 3) iret = 1;
      if ($urandom_range(999) < 3) drsp = 1;
      if (m_st == 6 && $urandom_range(99) < 10) do_reset();
      else cycle();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule